// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block watches three core buses every clock: the instruction fetch address, the load/store effective address and the load/store data value. It holds a bank of eight comparators, each with its own programmed reference value and test condition. Four comparators look at the fetch address. Two look at the load/store address, and two look at the load/store data. Every comparison is unsigned and 32 bits wide. A comparator only reports a hit in a cycle in which the valid strobe of its bus is high.

The comparator hits are combined into six watchpoints. Watchpoints 0 to 3 each follow one fetch comparator. Watchpoints 4 and 5 each need an address hit and a data hit in the same load/store cycle. Each watchpoint has its own event counter. The counter turns every N-th watchpoint event into a breakpoint pulse that lasts one cycle, and then starts counting again.

Debug software sets the unit up through a single-cycle register write port. Halting the core, trace capture and any debug transport are handled outside this block.

Top module: `wpu_top`

## Requirements
- R1: After reset, `watchOut` and `brkOut` are all low, every watchpoint is disabled, and every reference value, condition and count is zero. A bus cycle that a zero configuration would match produces no watchpoint.
- R2: A write (`cfgWe` high for one cycle) is decoded from `cfgAddr[4:3]`:
  - 0 writes the reference value of comparator `cfgAddr[2:0]` from `cfgData`.
  - 1 writes that comparator's condition from `cfgData[1:0]`.
  - 2 writes the control of watchpoint `cfgAddr[2:0]` (0 to 5), where `cfgData[15:0]` is the event count and `cfgData[16]` is the enable.
- R3: Condition codes, applied as unsigned 32-bit tests: 0 means bus equals reference, 1 means bus differs from reference, 2 means bus is below reference, 3 means bus is above reference.
- R4: Comparators 0 to 3 test `ifAddr`. Watchpoint k (k = 0 to 3) is bit k of `watchOut` and follows comparator k alone.
- R5: Watchpoint 4 is comparator 4 (on `lsAddr`) ANDed with comparator 6 (on `lsData`). Watchpoint 5 is comparator 5 (on `lsAddr`) ANDed with comparator 7 (on `lsData`).
- R6: A comparator hits only when its bus valid strobe (`ifValid` or `lsValid`) is high. A watchpoint output rises in the cycle after the bus cycle that caused it. A disabled watchpoint never asserts.
- R7: With an event count N of 2 or more, `brkOut[k]` goes high together with `watchOut[k]` on every N-th event of that watchpoint. It is a single-cycle pulse, after which counting starts again from zero.
- R8: An event count of 0 or 1 makes every event of that watchpoint a breakpoint.
- R9: Any write to a register that feeds a watchpoint restarts that watchpoint's event count from zero. This covers its control register, and the reference value or condition of any comparator it uses.
- R10: Writes with `cfgAddr[4:3]` = 3, and control writes to watchpoint indices 6 or 7, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 5 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| ifValid | input | 1 | Fetch address valid |
| ifAddr | input | 32 | Instruction fetch address |
| lsValid | input | 1 | Load/store cycle valid |
| lsAddr | input | 32 | Load/store effective address |
| lsData | input | 32 | Load/store data value |
| watchOut | output | 6 | Watchpoint outputs, one bit per watchpoint |
| brkOut | output | 6 | Breakpoint pulses, one bit per watchpoint |

## Verification
The assertions check four things on every cycle:
- a breakpoint never appears without its watchpoint;
- a watchpoint never asserts while disabled, or without a valid strobe on its bus in the cycle before;
- a count of 0 or 1 turns every event into a breakpoint;
- with a count of 2 or more, two breakpoints never come in back-to-back cycles.

Only the bench scenarios can show the rest:
- that each condition code compares correctly, including the unsigned order of values with the top bit set;
- that the two load/store watchpoints pair the right comparators;
- that the N-th event, and no other, fires;
- that a write to a feeding comparator restarts the count, and that writes to unused addresses change nothing.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int WPU_IF_CMPS  = 4;
  localparam int WPU_LS_PAIRS = 2;
  localparam int WPU_CMPS     = WPU_IF_CMPS + 2 * WPU_LS_PAIRS;
  localparam int WPU_WPS      = WPU_IF_CMPS + WPU_LS_PAIRS;
  localparam int WPU_IDX_W    = 3;
  localparam int WPU_ADDR_W   = WPU_IDX_W + 2;

  typedef enum logic [1:0] {
    CND_EQ = 2'd0,
    CND_NE = 2'd1,
    CND_LT = 2'd2,
    CND_GT = 2'd3
  } wpuCond_e;

  typedef enum logic [1:0] {
    RGN_VALUE = 2'd0,
    RGN_COND  = 2'd1,
    RGN_CTRL  = 2'd2,
    RGN_NONE  = 2'd3
  } wpuRegion_e;

  typedef struct packed {
    logic [WPU_CMPS-1:0] valWr;
    logic [WPU_CMPS-1:0] condWr;
    logic [WPU_WPS-1:0]  ctlWr;
  } wpuStrobe_t;
endpackage

// File: rtl/wpu_ctrl.sv
module wpu_ctrl
  import wpu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            cfgWe,
  input  logic [WPU_ADDR_W-1:0]           cfgAddr,
  input  logic [WPU_WPS-1:0]              watch,
  input  logic [WPU_WPS-1:0][CNT_W-1:0]   cntLimit,
  output wpuStrobe_t                      strobe,
  output logic [WPU_WPS-1:0]              brk
);
  localparam int SUM_W = CNT_W + 1;

  logic [WPU_IDX_W-1:0] regIdx;
  wpuRegion_e           region;
  logic [WPU_WPS-1:0]   clr;

  assign regIdx = cfgAddr[WPU_IDX_W-1:0];
  assign region = wpuRegion_e'(cfgAddr[WPU_ADDR_W-1 -: 2]);

  // Turn one register write into per-register strobes
  always_comb begin
    strobe = '0;
    if (cfgWe) begin
      unique case (region)
        RGN_VALUE: if (int'(regIdx) < WPU_CMPS) strobe.valWr[regIdx] = 1'b1;
        RGN_COND:  if (int'(regIdx) < WPU_CMPS) strobe.condWr[regIdx] = 1'b1;
        RGN_CTRL:  if (int'(regIdx) < WPU_WPS)  strobe.ctlWr[regIdx] = 1'b1;
        default: ;
      endcase
    end
  end

  // A watchpoint's first comparator has the watchpoint's own index;
  // a load/store watchpoint also uses the data comparator WPU_LS_PAIRS above it
  for (genvar w = 0; w < WPU_WPS; w++) begin : g_evt
    logic [CNT_W-1:0] evCnt;
    logic             reached;

    if (w < WPU_IF_CMPS) begin : g_if
      assign clr[w] = strobe.ctlWr[w] | strobe.valWr[w] | strobe.condWr[w];
    end else begin : g_ls
      assign clr[w] = strobe.ctlWr[w] | strobe.valWr[w] | strobe.condWr[w]
                    | strobe.valWr[w + WPU_LS_PAIRS] | strobe.condWr[w + WPU_LS_PAIRS];
    end

    assign reached = ({1'b0, evCnt} + SUM_W'(1)) >= {1'b0, cntLimit[w]};
    assign brk[w]  = watch[w] & reached;

    always_ff @(posedge clk) begin
      if (!rstN)         evCnt <= '0;
      else if (clr[w])   evCnt <= '0;
      else if (watch[w]) evCnt <= reached ? '0 : evCnt + 1'b1;
    end
  end
endmodule

// File: rtl/wpu_datapath.sv
module wpu_datapath
  import wpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  wpuStrobe_t                      strobe,
  input  logic [DATA_W-1:0]               cfgData,
  input  logic                            ifValid,
  input  logic [DATA_W-1:0]               ifAddr,
  input  logic                            lsValid,
  input  logic [DATA_W-1:0]               lsAddr,
  input  logic [DATA_W-1:0]               lsData,
  output logic [WPU_WPS-1:0]              watch,
  output logic [WPU_WPS-1:0][CNT_W-1:0]   cntLimit,
  output logic [WPU_WPS-1:0]              wpEnable
);
  localparam int EN_BIT = CNT_W;

  logic [WPU_CMPS-1:0] hit;
  logic [WPU_WPS-1:0]  wpRaw;

  for (genvar i = 0; i < WPU_CMPS; i++) begin : g_cmp
    logic [DATA_W-1:0] busVal;
    logic              busOn;
    logic [DATA_W-1:0] refVal;
    wpuCond_e          cond;
    logic              match;

    if (i < WPU_IF_CMPS) begin : g_ifBus
      assign busVal = ifAddr;
      assign busOn  = ifValid;
    end else if (i < WPU_IF_CMPS + WPU_LS_PAIRS) begin : g_lsAddrBus
      assign busVal = lsAddr;
      assign busOn  = lsValid;
    end else begin : g_lsDataBus
      assign busVal = lsData;
      assign busOn  = lsValid;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        refVal <= '0;
        cond   <= CND_EQ;
      end else begin
        if (strobe.valWr[i])  refVal <= cfgData;
        if (strobe.condWr[i]) cond   <= wpuCond_e'(cfgData[1:0]);
      end
    end

    always_comb begin
      unique case (cond)
        CND_EQ:  match = (busVal == refVal);
        CND_NE:  match = (busVal != refVal);
        CND_LT:  match = (busVal <  refVal);
        default: match = (busVal >  refVal);
      endcase
    end

    assign hit[i] = busOn & match;
  end

  for (genvar w = 0; w < WPU_WPS; w++) begin : g_wp
    logic [CNT_W-1:0] limReg;
    logic             enReg;

    if (w < WPU_IF_CMPS) begin : g_single
      assign wpRaw[w] = hit[w];
    end else begin : g_pair
      assign wpRaw[w] = hit[w] & hit[w + WPU_LS_PAIRS];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        limReg <= '0;
        enReg  <= 1'b0;
      end else if (strobe.ctlWr[w]) begin
        limReg <= cfgData[CNT_W-1:0];
        enReg  <= cfgData[EN_BIT];
      end
    end

    assign cntLimit[w] = limReg;
    assign wpEnable[w] = enReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) watch <= '0;
    else       watch <= wpRaw & wpEnable;
  end
endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [WPU_ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0]     cfgData,
  input  logic                  ifValid,
  input  logic [DATA_W-1:0]     ifAddr,
  input  logic                  lsValid,
  input  logic [DATA_W-1:0]     lsAddr,
  input  logic [DATA_W-1:0]     lsData,
  output logic [WPU_WPS-1:0]    watchOut,
  output logic [WPU_WPS-1:0]    brkOut
);
  wpuStrobe_t                    strobe;
  logic [WPU_WPS-1:0][CNT_W-1:0] cntLimit;
  logic [WPU_WPS-1:0]            wpEnable;

  wpu_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .ifValid(ifValid), .ifAddr(ifAddr), .lsValid(lsValid),
    .lsAddr(lsAddr), .lsData(lsData),
    .watch(watchOut), .cntLimit(cntLimit), .wpEnable(wpEnable)
  );

  wpu_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .watch(watchOut), .cntLimit(cntLimit), .strobe(strobe), .brk(brkOut)
  );
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker
  import wpu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          cfgWe,
  input logic                          ifValid,
  input logic                          lsValid,
  input logic [WPU_WPS-1:0]            watchOut,
  input logic [WPU_WPS-1:0]            brkOut,
  input logic [WPU_WPS-1:0]            wpEnable,
  input logic [WPU_WPS-1:0][CNT_W-1:0] cntLimit
);
  for (genvar w = 0; w < WPU_WPS; w++) begin : g_chk
    AST_BRK_WITH_WATCH: assert property (@(posedge clk) disable iff (!rstN)
      brkOut[w] |-> watchOut[w]); // R7
    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      watchOut[w] |-> $past(wpEnable[w])); // R6
    AST_EVERY_EVENT: assert property (@(posedge clk) disable iff (!rstN)
      (watchOut[w] && cntLimit[w] <= CNT_W'(1)) |-> brkOut[w]); // R8
    AST_BRK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
      (brkOut[w] && cntLimit[w] >= CNT_W'(2) && !cfgWe) |=> !brkOut[w]); // R7
    if (w < WPU_IF_CMPS) begin : g_ifGate
      AST_IF_VALID_GATE: assert property (@(posedge clk) disable iff (!rstN)
        watchOut[w] |-> $past(ifValid)); // R6
    end else begin : g_lsGate
      AST_LS_VALID_GATE: assert property (@(posedge clk) disable iff (!rstN)
        watchOut[w] |-> $past(lsValid)); // R5
    end
  end
endmodule

bind wpu_top wpu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .ifValid(ifValid), .lsValid(lsValid),
  .watchOut(watchOut), .brkOut(brkOut), .wpEnable(wpEnable), .cntLimit(cntLimit)
);

// File: tb/wpu_top_bench.sv
module wpu_top_bench;
  import wpu_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [4:0]  cfgAddr;
  logic [31:0] cfgData;
  logic        ifValid;
  logic [31:0] ifAddr;
  logic        lsValid;
  logic [31:0] lsAddr;
  logic [31:0] lsData;
  logic [5:0]  watchOut;
  logic [5:0]  brkOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  always #10 clk = ~clk;

  wpu_top u_wpu_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .ifValid(ifValid), .ifAddr(ifAddr), .lsValid(lsValid), .lsAddr(lsAddr),
    .lsData(lsData), .watchOut(watchOut), .brkOut(brkOut)
  );

  typedef struct packed {
    logic        ifV;
    logic [31:0] ifA;
    logic        lsV;
    logic [31:0] lsA;
    logic [31:0] lsD;
    logic [5:0]  expW;
  } vec_t;

  // cmp0 EQ 0x1000, cmp1 NE 0x1000, cmp2 LT 0x2000, cmp3 GT 0x80000000,
  // cmp4 EQ 0x4000 / cmp6 GT 0x10, cmp5 LT 0x100 / cmp7 NE 0
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 32'h0000_1000, 1'b0, 32'h0,      32'h0,         6'b000101},
    '{1'b1, 32'h0000_2000, 1'b0, 32'h0,      32'h0,         6'b000010},
    '{1'b1, 32'hF000_0000, 1'b0, 32'h0,      32'h0,         6'b001010},
    '{1'b0, 32'h0000_1000, 1'b1, 32'h4000,   32'h11,        6'b010000},
    '{1'b0, 32'h0000_1000, 1'b1, 32'h4000,   32'h10,        6'b000000},
    '{1'b0, 32'h0000_1000, 1'b1, 32'h80,     32'h5,         6'b100000},
    '{1'b0, 32'h0000_1000, 1'b1, 32'h80,     32'h0,         6'b000000},
    '{1'b1, 32'h0000_1FFF, 1'b0, 32'h80,     32'h5,         6'b000110},
    '{1'b0, 32'h0000_1000, 1'b0, 32'h4000,   32'h11,        6'b000000},
    '{1'b1, 32'h0000_0000, 1'b1, 32'h4000,   32'hFFFF_FFFF, 6'b010110}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    ifValid = 1'b0; lsValid = 1'b0;
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic step(input logic iv, input logic [31:0] ia, input logic lv,
                      input logic [31:0] la, input logic [31:0] ld);
    ifValid = iv; ifAddr = ia; lsValid = lv; lsAddr = la; lsData = ld;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgAddr = '0; cfgData = '0;
    ifValid = 1'b0; ifAddr = '0; lsValid = 1'b0; lsAddr = '0; lsData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1 watch after reset", 32'(watchOut), 32'h0);
    chk("R1 brk after reset", 32'(brkOut), 32'h0);
    // zero config would match EQ 0, but every watchpoint is disabled
    step(1'b1, 32'h0, 1'b1, 32'h0, 32'h0);
    chk("R1 disabled after reset", 32'(watchOut), 32'h0);
    chk("R1 brk stays low", 32'(brkOut), 32'h0);

    // R2 programming: values, conditions, controls
    wr(5'd0, 32'h0000_1000); wr(5'd1, 32'h0000_1000);
    wr(5'd2, 32'h0000_2000); wr(5'd3, 32'h8000_0000);
    wr(5'd4, 32'h0000_4000); wr(5'd5, 32'h0000_0100);
    wr(5'd6, 32'h0000_0010); wr(5'd7, 32'h0000_0000);
    wr(5'd8, 32'd0);  wr(5'd9, 32'd1);  wr(5'd10, 32'd2); wr(5'd11, 32'd3);
    wr(5'd12, 32'd0); wr(5'd13, 32'd2); wr(5'd14, 32'd3); wr(5'd15, 32'd1);
    for (int w = 0; w < 6; w++) wr(5'(16 + w), 32'h0001_0001);

    // Table: R3 conditions, R4 fetch watchpoints, R5 paired ones, R6 gating, R8 count 1
    for (int v = 0; v < NVEC; v++) begin
      step(VECS[v].ifV, VECS[v].ifA, VECS[v].lsV, VECS[v].lsA, VECS[v].lsD);
      chk($sformatf("R3 R4 R5 R6 watch vec %0d", v), 32'(watchOut), 32'(VECS[v].expW));
      chk($sformatf("R8 brk vec %0d", v), 32'(brkOut), 32'(VECS[v].expW));
    end

    // R7: count 3 on watchpoint 0
    wr(5'd16, 32'h0001_0003);
    for (int k = 1; k <= 7; k++) begin
      step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
      chk($sformatf("R7 watch0 event %0d", k), 32'(watchOut[0]), 32'h1);
      chk($sformatf("R7 brk0 event %0d", k), 32'(brkOut[0]), 32'((k % 3) == 0));
    end
    step(1'b1, 32'h3000, 1'b0, 32'h0, 32'h0);
    chk("R7 no match no brk", 32'(brkOut[0]), 32'h0);
    step(1'b1, 32'h3000, 1'b0, 32'h0, 32'h0);
    step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
    chk("R7 event 8 quiet", 32'(brkOut[0]), 32'h0);
    step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
    chk("R7 event 9 fires", 32'(brkOut[0]), 32'h1);

    // R9: one event, then a comparator write restarts the count
    step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
    chk("R9 pre-write event quiet", 32'(brkOut[0]), 32'h0);
    wr(5'd0, 32'h0000_1000);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
      chk($sformatf("R9 restarted event %0d", k), 32'(brkOut[0]), 32'(k == 3));
    end

    // R8: count 0 fires every event
    wr(5'd17, 32'h0001_0000);
    for (int k = 1; k <= 3; k++) begin
      step(1'b1, 32'h2000, 1'b0, 32'h0, 32'h0);
      chk($sformatf("R8 count0 event %0d", k), 32'(brkOut[1]), 32'h1);
    end

    // R6: disabling watchpoint 2
    wr(5'd18, 32'h0000_0000);
    step(1'b1, 32'h1000, 1'b0, 32'h0, 32'h0);
    chk("R6 disabled watch2", 32'(watchOut[2]), 32'h0);
    chk("R6 disabled brk2", 32'(brkOut[2]), 32'h0);

    // R10: unused addresses change nothing
    wr(5'd22, 32'h0);
    wr(5'd30, 32'h0);
    wr(5'd24, 32'h0);
    step(1'b1, 32'h1000, 1'b1, 32'h4000, 32'h11);
    chk("R10 unused writes ignored", 32'(watchOut), 32'h11);

    // R2 R3: switch comparator 3 to below-reference
    wr(5'd11, 32'd2);
    step(1'b1, 32'h10, 1'b0, 32'h0, 32'h0);
    chk("R2 R3 cmp3 now LT", 32'(watchOut[3]), 32'h1);

    step(1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
    chk("R6 idle bus quiet", 32'(watchOut), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule